// File: doc/BRIEF.md
# Asymmetric SCL Timing Generator

This block times the clock line of an I2C master from the system clock. While a transfer request is held, it produces one bit period after another. Each bit period has a low phase followed by a high phase. The bit engine receives the level of the clock line, a one-cycle strobe that marks when SDA may change, a strobe that marks when SDA is sampled, and a strobe on the last cycle of every bit.

The divider is 12 bits wide and comes in two separate pieces: a 10-bit lower part and a 2-bit upper part. The block joins them with the upper part as bits 11:10. The mode bit selects one of two timing schemes:

- **Legacy quarter-period mode:** the divider D is the length of one quarter of the period. The low phase takes two quarters. The high phase takes two quarters plus a fixed delay that covers the input filter.
- **High/low mode:** the high phase is D plus the filter delay, and the low phase takes its own 12-bit count. With separate counts, the duty cycle can be unbalanced, for example about 40 % high and 60 % low for the fast modes.

The configuration is captured only when a transfer starts from idle. Changes made to the fields during a transfer therefore apply from the next start. The states are IDLE, LOW_PH and HIGH_PH. The transitions are:

- IDLE to LOW_PH on start.
- LOW_PH to HIGH_PH at the end of the low phase.
- HIGH_PH to LOW_PH at the end of the bit while the request is still held.
- HIGH_PH to IDLE at the end of the bit once the request is gone.

Top module: `scl_tgen`

## Requirements
- R1: After reset, and whenever the generator is idle, `scl_out` is 1 and `busy` is 0, and none of the three strobes is active.
- R2: The divider D is formed as `{div_upper[1:0], div_lower[9:0]}`, so `div_upper` supplies divider bits 11:10.
- R3: With `hl_mode` = 0, the low phase lasts 2·D cycles and the high phase lasts 2·D + 15 cycles.
- R4: With `hl_mode` = 1, the low phase lasts `low_count` cycles and the high phase lasts D + 15 cycles.
- R5: A divider or low count of 0 is used as 1.
- R6: `sda_change` is high for exactly one cycle per bit. That cycle is cycle number ⌊low_len/2⌋ of the low phase, where the first cycle is numbered 0.
- R7: `sda_sample` is high for exactly one cycle per bit. That cycle is cycle number ⌊high_len/2⌋ of the high phase, where the first cycle is numbered 0.
- R8: `bit_done` is high on the last cycle of the high phase. If `run` is high in that cycle, the next cycle starts the low phase of a new bit. Otherwise the generator returns to idle.
- R9: The divider, low count and mode are captured only on the cycle a transfer starts from idle. Changing them during a transfer has no effect on the bits of that transfer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| run | input | 1 | Transfer request; the level is held for as long as bits are wanted |
| div_lower | input | 10 | Divider bits 9:0 |
| div_upper | input | 2 | Divider bits 11:10 |
| low_count | input | 12 | Low-phase length used in high/low mode |
| hl_mode | input | 1 | 1 selects high/low mode, 0 selects legacy quarter-period mode |
| scl_out | output | 1 | Clock line level (0 in the low phase) |
| busy | output | 1 | A bit period is in progress |
| sda_change | output | 1 | One-cycle strobe in the middle of the low phase |
| sda_sample | output | 1 | One-cycle strobe in the middle of the high phase |
| bit_done | output | 1 | One-cycle strobe on the last cycle of each bit |

## Verification
The assertions assume that `run` is driven cleanly and synchronously. They make no assumption about the configuration fields, which may change at any time, because the captured lengths are checked for stability over the whole busy interval. The stimulus changes the fields only on falling clock edges. It also changes them deliberately in the middle of a transfer, so that the capture rule is exercised and not just taken for granted. Dropping `run` happens only on the sample where `bit_done` is seen, which exercises both the continue path and the stop path.

// File: rtl/scl_tgen_pkg.sv
package scl_tgen_pkg;
    localparam int DIV_W    = 12;
    localparam int DIV_LO_W = 10;
    localparam int DIV_HI_W = DIV_W - DIV_LO_W;
    localparam int LEN_W    = DIV_W + 2;

    typedef enum logic [1:0] {
        IDLE    = 2'd0,
        LOW_PH  = 2'd1,
        HIGH_PH = 2'd2
    } scl_state_e;
endpackage

// File: rtl/scl_div_decode.sv
module scl_div_decode
    import scl_tgen_pkg::*;
#(
    parameter int FILTER_DLY = 15
) (
    input  logic [DIV_LO_W-1:0] div_lower,
    input  logic [DIV_HI_W-1:0] div_upper,
    input  logic [DIV_W-1:0]    low_count,
    input  logic                hl_mode,
    output logic [LEN_W-1:0]    low_len,
    output logic [LEN_W-1:0]    high_len
);
    logic [DIV_W-1:0] div_raw;
    logic [LEN_W-1:0] div_eff;
    logic [LEN_W-1:0] lc_eff;

    always_comb begin
        div_raw = {div_upper, div_lower};
        div_eff = (div_raw == '0) ? LEN_W'(1) : LEN_W'(div_raw);
        lc_eff  = (low_count == '0) ? LEN_W'(1) : LEN_W'(low_count);
        if (hl_mode) begin
            low_len  = lc_eff;
            high_len = div_eff + LEN_W'(FILTER_DLY);
        end else begin
            low_len  = div_eff << 1;
            high_len = (div_eff << 1) + LEN_W'(FILTER_DLY);
        end
    end
endmodule

// File: rtl/scl_cfg_hold.sv
module scl_cfg_hold
    import scl_tgen_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [LEN_W-1:0] low_len_d,
    input  logic [LEN_W-1:0] high_len_d,
    output logic [LEN_W-1:0] low_len_q,
    output logic [LEN_W-1:0] high_len_q
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            low_len_q  <= LEN_W'(1);
            high_len_q <= LEN_W'(1);
        end else if (load) begin
            low_len_q  <= low_len_d;
            high_len_q <= high_len_d;
        end
    end
endmodule

// File: rtl/scl_phase_ctr.sv
module scl_phase_ctr
    import scl_tgen_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             hold,
    input  logic [LEN_W-1:0] phase_len,
    output logic             phase_end,
    output logic             phase_mid
);
    logic [LEN_W-1:0] cnt_q;

    always_comb begin
        phase_end = !hold && (cnt_q == phase_len - LEN_W'(1));
        phase_mid = !hold && (cnt_q == (phase_len >> 1));
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            cnt_q <= '0;
        else if (hold || phase_end)
            cnt_q <= '0;
        else
            cnt_q <= cnt_q + LEN_W'(1);
    end
endmodule

// File: rtl/scl_tgen.sv
module scl_tgen
    import scl_tgen_pkg::*;
#(
    parameter int FILTER_DLY = 15
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                run,
    input  logic [DIV_LO_W-1:0] div_lower,
    input  logic [DIV_HI_W-1:0] div_upper,
    input  logic [DIV_W-1:0]    low_count,
    input  logic                hl_mode,
    output logic                scl_out,
    output logic                busy,
    output logic                sda_change,
    output logic                sda_sample,
    output logic                bit_done
);
    scl_state_e       state_q, state_d;
    logic [LEN_W-1:0] low_len_d, high_len_d;
    logic [LEN_W-1:0] low_len_q, high_len_q;
    logic [LEN_W-1:0] cur_len;
    logic             load, ph_end, ph_mid, ctr_hold;

    scl_div_decode #(.FILTER_DLY(FILTER_DLY)) u_dec (
        .div_lower (div_lower),
        .div_upper (div_upper),
        .low_count (low_count),
        .hl_mode   (hl_mode),
        .low_len   (low_len_d),
        .high_len  (high_len_d)
    );

    scl_cfg_hold u_hold (
        .clk        (clk),
        .rst_n      (rst_n),
        .load       (load),
        .low_len_d  (low_len_d),
        .high_len_d (high_len_d),
        .low_len_q  (low_len_q),
        .high_len_q (high_len_q)
    );

    assign cur_len  = (state_q == HIGH_PH) ? high_len_q : low_len_q;
    assign ctr_hold = (state_q == IDLE);

    scl_phase_ctr u_ctr (
        .clk       (clk),
        .rst_n     (rst_n),
        .hold      (ctr_hold),
        .phase_len (cur_len),
        .phase_end (ph_end),
        .phase_mid (ph_mid)
    );

    always_comb begin
        state_d = state_q;
        load    = 1'b0;
        unique case (state_q)
            IDLE: begin
                if (run) begin
                    load    = 1'b1;
                    state_d = LOW_PH;
                end
            end
            LOW_PH: begin
                if (ph_end) state_d = HIGH_PH;
            end
            HIGH_PH: begin
                if (ph_end) state_d = run ? LOW_PH : IDLE;
            end
            default: state_d = IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        scl_out    = (state_q != LOW_PH);
        busy       = (state_q != IDLE);
        sda_change = (state_q == LOW_PH)  && ph_mid;
        sda_sample = (state_q == HIGH_PH) && ph_mid;
        bit_done   = (state_q == HIGH_PH) && ph_end;
    end
endmodule

// File: rtl/scl_tgen_chk.sv
module scl_tgen_chk
    import scl_tgen_pkg::*;
#(
    parameter int FILTER_DLY = 15
) (
    input logic             clk,
    input logic             rst_n,
    input logic             run,
    input logic             scl_out,
    input logic             busy,
    input logic             sda_change,
    input logic             sda_sample,
    input logic             bit_done,
    input logic [LEN_W-1:0] low_len,
    input logic [LEN_W-1:0] high_len
);
    assert_idle_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (scl_out && !sda_change && !sda_sample && !bit_done));

    assert_len_floor_R5: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> (low_len != '0 && high_len > LEN_W'(FILTER_DLY)));

    assert_change_low_R6: assert property (@(posedge clk) disable iff (!rst_n)
        sda_change |-> (busy && !scl_out));

    assert_change_single_R6: assert property (@(posedge clk) disable iff (!rst_n)
        sda_change |=> !sda_change);

    assert_sample_high_R7: assert property (@(posedge clk) disable iff (!rst_n)
        sda_sample |-> (busy && scl_out));

    assert_done_high_R8: assert property (@(posedge clk) disable iff (!rst_n)
        bit_done |-> (busy && scl_out));

    assert_done_stop_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (bit_done && !run) |=> !busy);

    assert_done_next_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (bit_done && run) |=> (busy && !scl_out));

    assert_cfg_stable_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && $past(busy)) |-> ($stable(low_len) && $stable(high_len)));
endmodule

bind scl_tgen scl_tgen_chk #(.FILTER_DLY(FILTER_DLY)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .run        (run),
    .scl_out    (scl_out),
    .busy       (busy),
    .sda_change (sda_change),
    .sda_sample (sda_sample),
    .bit_done   (bit_done),
    .low_len    (low_len_q),
    .high_len   (high_len_q)
);

// File: tb/scl_tgen_bench.sv
module scl_tgen_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        run = 1'b0;
    logic [9:0]  div_lower = '0;
    logic [1:0]  div_upper = '0;
    logic [11:0] low_count = '0;
    logic        hl_mode = 1'b0;
    logic        scl_out, busy, sda_change, sda_sample, bit_done;

    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;

    always #2 clk = ~clk;

    scl_tgen u_scl_tgen (
        .clk        (clk),
        .rst_n      (rst_n),
        .run        (run),
        .div_lower  (div_lower),
        .div_upper  (div_upper),
        .low_count  (low_count),
        .hl_mode    (hl_mode),
        .scl_out    (scl_out),
        .busy       (busy),
        .sda_change (sda_change),
        .sda_sample (sda_sample),
        .bit_done   (bit_done)
    );

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Expected lengths from R2..R5
    function automatic int exp_low(input int d_raw, input int lc, input bit hl);
        int d = (d_raw == 0) ? 1 : d_raw;
        int l = (lc == 0) ? 1 : lc;
        return hl ? l : 2 * d;
    endfunction

    function automatic int exp_high(input int d_raw, input bit hl);
        int d = (d_raw == 0) ? 1 : d_raw;
        return hl ? d + 15 : 2 * d + 15;
    endfunction

    task automatic set_cfg(input int d, input int lc, input bit hl);
        div_lower = d[9:0];
        div_upper = d[11:10];
        low_count = lc[11:0];
        hl_mode   = hl;
    endtask

    // Called on a negedge where the low phase has just begun.
    task automatic measure_bit(input bit last, output int lcyc, output int ci,
                               output int hcyc, output int si, output int nchg, output int nsmp);
        lcyc = 0; ci = -1; hcyc = 0; si = -1; nchg = 0; nsmp = 0;
        while (scl_out == 1'b0 && lcyc < 20000) begin
            if (sda_change) begin ci = lcyc; nchg++; end
            lcyc++;
            @(negedge clk);
        end
        while (hcyc < 20000) begin
            if (sda_sample) begin si = hcyc; nsmp++; end
            hcyc++;
            if (bit_done) begin
                if (last) run = 1'b0;
                break;
            end
            @(negedge clk);
        end
        @(negedge clk);
    endtask

    task automatic check_bit(input string tag, input int el, input int eh,
                             input int lcyc, input int ci, input int hcyc,
                             input int si, input int nchg, input int nsmp);
        chk({tag, " R3/R4 low length"}, lcyc, el);
        chk({tag, " R3/R4 high length R8"}, hcyc, eh);
        chk({tag, " R6 change point"}, ci, el / 2);
        chk({tag, " R6 change count"}, nchg, 1);
        chk({tag, " R7 sample point"}, si, eh / 2);
        chk({tag, " R7 sample count"}, nsmp, 1);
    endtask

    task automatic one_bit(input string tag, input int d, input int lc, input bit hl);
        int lcyc, ci, hcyc, si, nchg, nsmp;
        set_cfg(d, lc, hl);
        run = 1'b1;
        @(negedge clk);
        measure_bit(1'b1, lcyc, ci, hcyc, si, nchg, nsmp);
        check_bit(tag, exp_low(d, lc, hl), exp_high(d, hl), lcyc, ci, hcyc, si, nchg, nsmp);
        chk({tag, " R8 idle after stop"}, int'(busy), 0);
        chk({tag, " R1 idle scl high"}, int'(scl_out), 1);
    endtask

    initial begin
        #(4 * 200000);
        if (!finished) begin
            errors++;
            checks++;
            $display("FAIL watchdog expired actual=1 expected=0");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        int lcyc, ci, hcyc, si, nchg, nsmp;
        repeat (3) @(negedge clk);
        chk("R1 reset scl", int'(scl_out), 1);
        chk("R1 reset busy", int'(busy), 0);
        chk("R1 reset strobes", int'(sda_change | sda_sample | bit_done), 0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        chk("R1 idle without run", int'(busy), 0);

        // R3 R5: legacy sweep, including D = 0
        for (int d = 0; d <= 6; d++) one_bit($sformatf("legacy d=%0d", d), d, 0, 1'b0);

        // R4 R5: high/low sweep, including zero fields
        for (int d = 0; d <= 4; d++)
            for (int lc = 0; lc <= 5; lc++)
                one_bit($sformatf("hl d=%0d lc=%0d", d, lc), d, lc, 1'b1);

        // R2: upper divider bits
        one_bit("R2 legacy upper", 12'h403, 0, 1'b0);
        one_bit("R2 hl upper", 12'h802, 12'h123, 1'b1);
        one_bit("R2 hl all ones", 12'hFFF, 12'hFFF, 1'b1);

        // R8 R9: three back-to-back bits, config changed during the first
        set_cfg(3, 7, 1'b1);
        run = 1'b1;
        @(negedge clk);
        set_cfg(9, 2, 1'b0);
        measure_bit(1'b0, lcyc, ci, hcyc, si, nchg, nsmp);
        check_bit("R9 bit0", 7, 18, lcyc, ci, hcyc, si, nchg, nsmp);
        chk("R8 continue low", int'(scl_out), 0);
        measure_bit(1'b0, lcyc, ci, hcyc, si, nchg, nsmp);
        check_bit("R9 bit1 held cfg", 7, 18, lcyc, ci, hcyc, si, nchg, nsmp);
        measure_bit(1'b1, lcyc, ci, hcyc, si, nchg, nsmp);
        check_bit("R9 bit2 held cfg", 7, 18, lcyc, ci, hcyc, si, nchg, nsmp);
        chk("R8 stop to idle", int'(busy), 0);

        // R9: new settings apply at the next start
        run = 1'b1;
        @(negedge clk);
        measure_bit(1'b1, lcyc, ci, hcyc, si, nchg, nsmp);
        check_bit("R9 next start", 18, 33, lcyc, ci, hcyc, si, nchg, nsmp);
        chk("R1 idle at end", int'(scl_out), 1);

        finished = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule